// File: doc/BRIEF.md
# Indexed CMOS Real-Time Clock Register File

This block is a battery-style real-time clock folded into a 128-byte register array. Software reaches it through two byte-wide ports that share one bus: the select port holds a 7-bit location number, and the data port reads or writes the byte at that location. Seven calendar bytes and a century byte live in the array in BCD. A sub-second phase counter, advanced by a 32.768 kHz enable, carries the calendar forward once per second.

Writes to calendar bytes are range-checked field by field. A rejected write leaves the old byte in place. When the whole date that results from an accepted write is plausible (year 1970 or later, month and day in range), the phase counter restarts, so the next seconds step comes one full second later. Status A reports an update-in-progress flag during the last ticks of each second. Status C reads as a fixed flag pattern. Status C and D refuse writes. Every other location is plain storage.

Top module: `rtc_regfile`

## Requirements
- R1: A write on the select port (bus_port=0) keeps only bits 6:0 of the byte as the current location, and a read on the select port always returns 0xFF.
- R2: After reset every location reads 0x00, except status A at 0x0A (0x26), status B at 0x0B (0x02), status D at 0x0D (0x80) and status C (see R4).
- R3: A data-port read of 0x0A returns the stored byte with bit 7 forced to 1 exactly while the phase counter is in its last UIP_TICKS values (phase >= 2^PHASE_W - UIP_TICKS), and bit 7 of the stored byte otherwise.
- R4: A data-port read of 0x0C always returns 0xA0.
- R5: Data writes to 0x0C and 0x0D are discarded, and 0x0D keeps reading 0x80.
- R6: A data write to a calendar location (seconds 0x00, minutes 0x02, hours 0x04, weekday 0x06, day 0x07, month 0x08, year 0x09, century 0x32) is stored only if both nibbles are 9 or less and the value is in range: seconds and minutes 0–59, hours 0–23, weekday 1–7, day 1–31, month 1–12, year and century 0–99; otherwise the old byte stays.
- R7: An accepted calendar write whose resulting date has century×100+year below 1970, or a month or day out of range, is stored but does not restart the phase counter.
- R8: An accepted calendar write with a valid resulting date restarts the phase at zero, so the seconds byte changes on the 2^PHASE_W-th tick after the write and not before.
- R9: A data write to any location that is neither a calendar byte nor status C or D stores the byte unchanged.
- R10: On each phase wrap the calendar advances one second in BCD, carrying seconds to minutes, hours, day, month, year and century; the weekday steps with the day and wraps from 7 to 1; the century wraps from 99 to 00.
- R11: The day carries after the last day of the month: 30 for April, June, September and November, 31 for the other months except February, which has 29 days in years divisible by 4 (but not by 100 unless divisible by 400) and 28 otherwise.
- R12: The phase counter advances only on cycles with tick_en high; with tick_en low the calendar does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per 32.768 kHz period |
| bus_wr | input | 1 | Write strobe for the port chosen by bus_port |
| bus_port | input | 1 | 0 = select port, 1 = data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte of the port chosen by bus_port |

## Verification
A corrupt phase counter shows up first as a misplaced update flag in status A, visible on the very next read of 0x0A, and then as a seconds step that arrives early or late; the bench counts ticks after every re-basing write to pin that step to one exact tick. A wrong carry in the calendar stays hidden until the affected field rolls over, so the bench presets dates at month, year and century ends and checks all eight calendar bytes one tick after the wrap. A bad field check leaves an out-of-range byte in the array, and this is read back right after the write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [6:0] IDX_SEC  = 7'h00;
  localparam logic [6:0] IDX_MIN  = 7'h02;
  localparam logic [6:0] IDX_HOUR = 7'h04;
  localparam logic [6:0] IDX_WDAY = 7'h06;
  localparam logic [6:0] IDX_DAY  = 7'h07;
  localparam logic [6:0] IDX_MON  = 7'h08;
  localparam logic [6:0] IDX_YEAR = 7'h09;
  localparam logic [6:0] IDX_STA  = 7'h0A;
  localparam logic [6:0] IDX_STB  = 7'h0B;
  localparam logic [6:0] IDX_STC  = 7'h0C;
  localparam logic [6:0] IDX_STD  = 7'h0D;
  localparam logic [6:0] IDX_CENT = 7'h32;

  localparam logic [7:0] STA_INIT = 8'h26;
  localparam logic [7:0] STB_INIT = 8'h02;
  localparam logic [7:0] STD_INIT = 8'h80;
  localparam logic [7:0] STC_READ = 8'hA0;
  localparam int unsigned MIN_YEAR = 1970;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
    logic [7:0] cent;
  } cal_t;

  function automatic logic bcd_ok(input logic [7:0] b);
    return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9);
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic leap_year(input logic [13:0] y);
    return (y % 14'd4 == 14'd0) && ((y % 14'd100 != 14'd0) || (y % 14'd400 == 14'd0));
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] m, input logic leap);
    case (m)
      7'd2:                      return leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction

  function automatic logic is_cal_idx(input logic [6:0] idx);
    return (idx == IDX_SEC) || (idx == IDX_MIN) || (idx == IDX_HOUR) ||
           (idx == IDX_WDAY) || (idx == IDX_DAY) || (idx == IDX_MON) ||
           (idx == IDX_YEAR) || (idx == IDX_CENT);
  endfunction

  function automatic logic field_ok(input logic [6:0] idx, input logic [7:0] v);
    logic [6:0] b;
    logic       rng;
    b = bcd2bin(v);
    case (idx)
      IDX_SEC, IDX_MIN: rng = (b <= 7'd59);
      IDX_HOUR:         rng = (b <= 7'd23);
      IDX_WDAY:         rng = (b >= 7'd1) && (b <= 7'd7);
      IDX_DAY:          rng = (b >= 7'd1) && (b <= 7'd31);
      IDX_MON:          rng = (b >= 7'd1) && (b <= 7'd12);
      default:          rng = (b <= 7'd99);
    endcase
    return bcd_ok(v) && rng;
  endfunction

endpackage

// File: rtl/rtc_phase.sv
module rtc_phase #(
  parameter int PHASE_W   = 15,
  parameter int UIP_TICKS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               restart,
  output logic [PHASE_W-1:0] phase,
  output logic               wrap,
  output logic               uip
);
  localparam logic [PHASE_W-1:0] PH_MAX    = '1;
  localparam logic [PHASE_W-1:0] UIP_START = PH_MAX - PHASE_W'(UIP_TICKS - 1);

  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        phase_q <= '0;
    else if (restart)  phase_q <= '0;
    else if (tick_en)  phase_q <= phase_q + 1'b1;
  end

  assign phase = phase_q;
  assign wrap  = tick_en && !restart && (phase_q == PH_MAX);
  assign uip   = (phase_q >= UIP_START);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  cal_t cur,
  output cal_t nxt
);
  logic [6:0]  s, m, h, w, d, mo, y, c, dim;
  logic [13:0] full_year;
  logic        cy_sec, cy_min, cy_hour, cy_day, cy_mon, cy_year;

  always_comb begin
    s  = bcd2bin(cur.sec);
    m  = bcd2bin(cur.min);
    h  = bcd2bin(cur.hour);
    w  = bcd2bin(cur.wday);
    d  = bcd2bin(cur.day);
    mo = bcd2bin(cur.mon);
    y  = bcd2bin(cur.year);
    c  = bcd2bin(cur.cent);
    full_year = 14'(c) * 14'd100 + 14'(y);
    dim       = month_len(mo, leap_year(full_year));

    cy_sec  = (s >= 7'd59);
    cy_min  = cy_sec  && (m >= 7'd59);
    cy_hour = cy_min  && (h >= 7'd23);
    cy_day  = cy_hour && (d >= dim);
    cy_mon  = cy_day  && (mo >= 7'd12);
    cy_year = cy_mon  && (y >= 7'd99);

    nxt.sec  = bin2bcd(cy_sec ? 7'd0 : s + 7'd1);
    nxt.min  = cy_sec  ? bin2bcd(cy_min  ? 7'd0 : m + 7'd1) : cur.min;
    nxt.hour = cy_min  ? bin2bcd(cy_hour ? 7'd0 : h + 7'd1) : cur.hour;
    nxt.wday = cy_hour ? bin2bcd((w >= 7'd7) ? 7'd1 : w + 7'd1) : cur.wday;
    nxt.day  = cy_hour ? bin2bcd(cy_day  ? 7'd1 : d + 7'd1) : cur.day;
    nxt.mon  = cy_day  ? bin2bcd(cy_mon  ? 7'd1 : mo + 7'd1) : cur.mon;
    nxt.year = cy_mon  ? bin2bcd(cy_year ? 7'd0 : y + 7'd1) : cur.year;
    nxt.cent = cy_year ? bin2bcd((c >= 7'd99) ? 7'd0 : c + 7'd1) : cur.cent;
  end
endmodule

// File: rtl/rtc_wcheck.sv
module rtc_wcheck
  import rtc_pkg::*;
(
  input  logic [6:0] idx,
  input  logic [7:0] wdata,
  input  cal_t       cur,
  output logic       is_cal,
  output logic       fld_ok,
  output logic       date_ok
);
  cal_t        t;
  logic [6:0]  mo, d;
  logic [13:0] full_year;

  always_comb begin
    t = cur;
    case (idx)
      IDX_SEC:  t.sec  = wdata;
      IDX_MIN:  t.min  = wdata;
      IDX_HOUR: t.hour = wdata;
      IDX_WDAY: t.wday = wdata;
      IDX_DAY:  t.day  = wdata;
      IDX_MON:  t.mon  = wdata;
      IDX_YEAR: t.year = wdata;
      IDX_CENT: t.cent = wdata;
      default:  t = cur;
    endcase
    mo        = bcd2bin(t.mon);
    d         = bcd2bin(t.day);
    full_year = 14'(bcd2bin(t.cent)) * 14'd100 + 14'(bcd2bin(t.year));
    is_cal    = is_cal_idx(idx);
    fld_ok    = field_ok(idx, wdata);
    date_ok   = (full_year >= 14'(MIN_YEAR)) && (mo >= 7'd1) && (mo <= 7'd12) &&
                (d >= 7'd1) && (d <= 7'd31);
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int PHASE_W   = 15,
  parameter int UIP_TICKS = 8,
  parameter int ADDR_W    = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       bus_wr,
  input  logic       bus_port,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        mem_q [DEPTH];
  logic [ADDR_W-1:0] idx_q;
  cal_t              cur, nxt;
  logic              data_wr, idx_wr, is_cal, fld_ok, date_ok;
  logic              ro_hit, time_acc, plain_wr, rebase;
  logic              wrap, uip;
  logic [PHASE_W-1:0] phase;
  logic [7:0]        sec_q, hour_q, reg_d_q;

  assign cur.sec  = mem_q[IDX_SEC];
  assign cur.min  = mem_q[IDX_MIN];
  assign cur.hour = mem_q[IDX_HOUR];
  assign cur.wday = mem_q[IDX_WDAY];
  assign cur.day  = mem_q[IDX_DAY];
  assign cur.mon  = mem_q[IDX_MON];
  assign cur.year = mem_q[IDX_YEAR];
  assign cur.cent = mem_q[IDX_CENT];

  assign sec_q   = mem_q[IDX_SEC];
  assign hour_q  = mem_q[IDX_HOUR];
  assign reg_d_q = mem_q[IDX_STD];

  assign data_wr  = bus_wr && bus_port;
  assign idx_wr   = bus_wr && !bus_port;
  assign ro_hit   = (idx_q == IDX_STC) || (idx_q == IDX_STD);
  assign time_acc = data_wr && is_cal && fld_ok;
  assign rebase   = time_acc && date_ok;
  assign plain_wr = data_wr && !is_cal && !ro_hit;

  rtc_wcheck u_wcheck (
    .idx     (idx_q),
    .wdata   (bus_wdata),
    .cur     (cur),
    .is_cal  (is_cal),
    .fld_ok  (fld_ok),
    .date_ok (date_ok)
  );

  rtc_calendar u_cal (
    .cur (cur),
    .nxt (nxt)
  );

  rtc_phase #(.PHASE_W(PHASE_W), .UIP_TICKS(UIP_TICKS)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .restart (rebase),
    .phase   (phase),
    .wrap    (wrap),
    .uip     (uip)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      mem_q[IDX_STA] <= STA_INIT;
      mem_q[IDX_STB] <= STB_INIT;
      mem_q[IDX_STD] <= STD_INIT;
      idx_q          <= '0;
    end else begin
      if (idx_wr) idx_q <= bus_wdata[ADDR_W-1:0];
      if (wrap) begin
        mem_q[IDX_SEC]  <= nxt.sec;
        mem_q[IDX_MIN]  <= nxt.min;
        mem_q[IDX_HOUR] <= nxt.hour;
        mem_q[IDX_WDAY] <= nxt.wday;
        mem_q[IDX_DAY]  <= nxt.day;
        mem_q[IDX_MON]  <= nxt.mon;
        mem_q[IDX_YEAR] <= nxt.year;
        mem_q[IDX_CENT] <= nxt.cent;
      end
      if (time_acc || plain_wr) mem_q[idx_q] <= bus_wdata;
    end
  end

  always_comb begin
    if (!bus_port)                bus_rdata = 8'hFF;
    else if (idx_q == IDX_STC)    bus_rdata = STC_READ;
    else if (idx_q == IDX_STA)    bus_rdata = mem_q[idx_q] | {uip, 7'b0};
    else                          bus_rdata = mem_q[idx_q];
  end
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
  import rtc_pkg::*;
#(
  parameter int PHASE_W   = 15,
  parameter int UIP_TICKS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_en,
  input logic               bus_port,
  input logic [7:0]         bus_rdata,
  input logic [6:0]         idx_q,
  input logic               data_wr,
  input logic               time_acc,
  input logic               rebase,
  input logic               wrap,
  input logic               uip,
  input logic [PHASE_W-1:0] phase,
  input logic [7:0]         sec_q,
  input logic [7:0]         hour_q,
  input logic [7:0]         reg_d_q
);
  localparam logic [PHASE_W-1:0] UIP_START = '1 - PHASE_W'(UIP_TICKS - 1);

  AST_SELECT_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_port |-> bus_rdata == 8'hFF); // R1
  AST_UIP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> uip); // R3
  AST_UIP_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> phase == UIP_START); // R3
  AST_STATUS_C_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_port && idx_q == IDX_STC) |-> bus_rdata == STC_READ); // R4
  AST_STATUS_D_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_q == IDX_STD) |=> reg_d_q == $past(reg_d_q)); // R5
  AST_SEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q[3:0] <= 4'd9 && sec_q <= 8'h59); // R6
  AST_HOUR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hour_q[3:0] <= 4'd9 && hour_q <= 8'h23); // R6
  AST_REBASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rebase |=> phase == '0); // R8
  AST_WRAP_STEPS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !time_acc) |=> sec_q != $past(sec_q)); // R10
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !rebase) |=> $stable(phase)); // R12
endmodule

bind rtc_regfile rtc_regfile_chk #(.PHASE_W(PHASE_W), .UIP_TICKS(UIP_TICKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .bus_port  (bus_port),
  .bus_rdata (bus_rdata),
  .idx_q     (idx_q),
  .data_wr   (data_wr),
  .time_acc  (time_acc),
  .rebase    (rebase),
  .wrap      (wrap),
  .uip       (uip),
  .phase     (phase),
  .sec_q     (sec_q),
  .hour_q    (hour_q),
  .reg_d_q   (reg_d_q)
);

// File: tb/tb_rtc_regfile.sv
`timescale 1ns/1ps
module tb_rtc_regfile;
  localparam int PW  = 6;
  localparam int SEC_TICKS = 1 << PW;
  localparam int UIPN = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_port = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] sh [128];

  always #2.5 clk = ~clk;

  rtc_regfile #(.PHASE_W(PW), .UIP_TICKS(UIPN)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic int fb(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] tb_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int mdays(input int m, input int y);
    if (m == 2) return (((y % 4) == 0 && (y % 100) != 0) || (y % 400) == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction
  function automatic bit cal_loc(input int i);
    return i == 0 || i == 2 || i == 4 || i == 6 || i == 7 || i == 8 || i == 9 || i == 'h32;
  endfunction
  function automatic bit accept(input int i, input logic [7:0] v);
    int b;
    if (v[7:4] > 9 || v[3:0] > 9) return 0;
    b = fb(v);
    case (i)
      0, 2:    return b <= 59;
      4:       return b <= 23;
      6:       return b >= 1 && b <= 7;
      7:       return b >= 1 && b <= 31;
      8:       return b >= 1 && b <= 12;
      default: return 1;
    endcase
  endfunction

  function automatic void model_write(input int i, input logic [7:0] v);
    if (cal_loc(i)) begin
      if (accept(i, v)) sh[i] = v;
    end else if (i != 'h0C && i != 'h0D) sh[i] = v;
  endfunction

  function automatic void model_second();
    int s, m, h, w, d, mo, y, c;
    s = fb(sh[0]); m = fb(sh[2]); h = fb(sh[4]); w = fb(sh[6]);
    d = fb(sh[7]); mo = fb(sh[8]); y = fb(sh[9]); c = fb(sh['h32]);
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin
          h = 0; w = (w >= 7) ? 1 : w + 1;
          if (d >= mdays(mo, c * 100 + y)) begin
            d = 1; mo++;
            if (mo > 12) begin
              mo = 1; y++;
              if (y > 99) begin y = 0; c = (c >= 99) ? 0 : c + 1; end
            end
          end else d++;
        end
      end
    end
    sh[0] = tb_bcd(s); sh[2] = tb_bcd(m); sh[4] = tb_bcd(h); sh[6] = tb_bcd(w);
    sh[7] = tb_bcd(d); sh[8] = tb_bcd(mo); sh[9] = tb_bcd(y); sh['h32] = tb_bcd(c);
  endfunction

  task automatic bus_write(input logic p, input logic [7:0] v);
    @(negedge clk);
    bus_port = p; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask
  task automatic reg_write(input int i, input logic [7:0] v);
    bus_write(1'b0, 8'(i));
    bus_write(1'b1, v);
    model_write(i, v);
  endtask
  task automatic reg_read(input int i, output logic [7:0] v);
    bus_write(1'b0, 8'(i));
    bus_port = 1'b1;
    #1 v = bus_rdata;
  endtask
  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic set_time(input int c, input int y, input int mo, input int d,
                          input int w, input int h, input int m, input int s);
    reg_write('h32, tb_bcd(c)); reg_write(9, tb_bcd(y)); reg_write(8, tb_bcd(mo));
    reg_write(7, tb_bcd(d)); reg_write(6, tb_bcd(w)); reg_write(4, tb_bcd(h));
    reg_write(2, tb_bcd(m)); reg_write(0, tb_bcd(s));
  endtask

  task automatic check_calendar(input string req);
    logic [7:0] v;
    int locs [8] = '{0, 2, 4, 6, 7, 8, 9, 'h32};
    foreach (locs[k]) begin
      reg_read(locs[k], v);
      check(req, v, sh[locs[k]]);
    end
  endtask

  // R8 R10 R11: one second after a re-basing write, compare every field
  task automatic one_second(input string req);
    logic [7:0] v;
    ticks(SEC_TICKS - 1);
    reg_read(0, v);
    check("R8 no step before full second", v, sh[0]);
    ticks(1);
    model_second();
    check_calendar(req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) sh[i] = 8'h00;
    sh['h0A] = 8'h26; sh['h0B] = 8'h02; sh['h0D] = 8'h80;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset values, R4 status C
    reg_read('h0A, v); check("R2 status A", v, 8'h26);
    reg_read('h0B, v); check("R2 status B", v, 8'h02);
    reg_read('h0D, v); check("R2 status D", v, 8'h80);
    reg_read('h0C, v); check("R4 status C", v, 8'hA0);
    reg_read(0, v);    check("R2 seconds", v, 8'h00);
    reg_read('h32, v); check("R2 century", v, 8'h00);
    reg_read('h7F, v); check("R2 top byte", v, 8'h00);

    // R1 select port
    bus_port = 1'b0; #1 check("R1 select read", bus_rdata, 8'hFF);
    bus_write(1'b0, 8'hC5); bus_write(1'b1, 8'h5A); sh['h45] = 8'h5A;
    reg_read('h45, v); check("R1 bit 7 dropped", v, 8'h5A);
    bus_port = 1'b0; #1 check("R1 select read after write", bus_rdata, 8'hFF);

    // R12 hold without ticks, then one second from reset phase
    repeat (150) @(negedge clk);
    reg_read(0, v); check("R12 hold seconds", v, 8'h00);
    ticks(SEC_TICKS);
    model_second();
    reg_read(0, v); check("R12 R10 first second", v, 8'h01);

    // directed calendar corners
    set_time(20, 24, 2, 28, 3, 23, 59, 59); one_second("R11 leap 2024");
    set_time(20, 23, 2, 28, 3, 23, 59, 59); one_second("R11 common 2023");
    set_time(20, 0, 2, 28, 2, 23, 59, 59);  one_second("R11 leap 2000");
    set_time(21, 0, 2, 28, 7, 23, 59, 59);  one_second("R11 common 2100");
    set_time(20, 24, 4, 30, 5, 23, 59, 59); one_second("R11 thirty day month");
    set_time(19, 99, 12, 31, 7, 23, 59, 59); one_second("R10 year and weekday wrap");
    set_time(99, 99, 12, 31, 6, 23, 59, 59); one_second("R10 century wrap");
    set_time(20, 13, 11, 13, 4, 2, 4, 56);  one_second("R10 plain second");

    // random calendar steps
    for (int n = 0; n < 12; n++) begin
      int c, y, mo, d, h, m, s;
      c  = 19 + int'($urandom % 3);
      y  = (c == 19) ? 70 + int'($urandom % 30) : int'($urandom % 100);
      mo = 1 + int'($urandom % 12);
      d  = ($urandom % 2) ? mdays(mo, c * 100 + y) : 1 + int'($urandom % mdays(mo, c * 100 + y));
      h  = ($urandom % 2) ? 23 : int'($urandom % 24);
      m  = ($urandom % 2) ? 59 : int'($urandom % 60);
      s  = ($urandom % 4 != 0) ? 59 : int'($urandom % 60);
      set_time(c, y, mo, d, 1 + int'($urandom % 7), h, m, s);
      one_second("R10 R11 random step");
    end

    // R3 update flag across a whole second after a re-basing write
    set_time(20, 24, 6, 15, 6, 12, 30, 10);
    reg_read('h0A, v); check("R3 flag clear after restart", v, 8'h26);
    for (int k = 1; k <= SEC_TICKS + 4; k++) begin
      ticks(1);
      #1 check("R3 status A flag", bus_rdata,
               8'h26 | (((k % SEC_TICKS) >= SEC_TICKS - UIPN) ? 8'h80 : 8'h00));
    end
    model_second();

    // R7 accepted write with invalid date does not restart the phase
    set_time(20, 24, 2, 28, 3, 23, 59, 59);
    ticks(30);
    reg_write('h32, 8'h19);
    reg_read('h32, v); check("R7 century stored", v, 8'h19);
    ticks(SEC_TICKS - 31);
    reg_read(0, v); check("R7 still before wrap", v, 8'h59);
    ticks(1);
    model_second();
    reg_read(0, v); check("R7 wrap kept old phase", v, 8'h00);
    reg_read(7, v); check("R7 R11 leap 1924", v, sh[7]);

    // R6 random calendar writes with range checks
    for (int n = 0; n < 48; n++) begin
      int locs [8] = '{0, 2, 4, 6, 7, 8, 9, 'h32};
      int i;
      logic [7:0] w;
      i = locs[$urandom % 8];
      w = ($urandom % 2) ? tb_bcd(int'($urandom % 100)) : 8'($urandom);
      reg_write(i, w);
      reg_read(i, v);
      check("R6 field check", v, sh[i]);
    end
    reg_write(2, 8'h60);  reg_read(2, v); check("R6 minute 60 kept old", v, sh[2]);
    reg_write(4, 8'h24);  reg_read(4, v); check("R6 hour 24 kept old", v, sh[4]);
    reg_write(6, 8'h00);  reg_read(6, v); check("R6 weekday 0 kept old", v, sh[6]);
    reg_write(8, 8'h1A);  reg_read(8, v); check("R6 bad nibble kept old", v, sh[8]);

    // R5 read-only status
    reg_write('h0D, 8'h11); reg_read('h0D, v); check("R5 status D kept", v, 8'h80);
    reg_write('h0C, 8'h00); reg_read('h0C, v); check("R5 R4 status C fixed", v, 8'hA0);

    // R9 plain storage
    for (int n = 0; n < 24; n++) begin
      int i;
      logic [7:0] w;
      do i = int'($urandom % 128);
      while (cal_loc(i) || i == 'h0A || i == 'h0C || i == 'h0D);
      w = 8'($urandom);
      reg_write(i, w);
      reg_read(i, v);
      check("R9 plain byte", v, w);
    end
    reg_write('h0B, 8'h5C); reg_read('h0B, v); check("R9 status B plain", v, 8'h5C);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule